// File: doc/BRIEF.md
# Event Notification Queue Writer

This block sits after the routing stage of an interrupt controller. Each routed notification carries a 31-bit event data word, a target number and a priority. The block turns every notification into a 4-byte record and writes it into a circular queue in system memory. There is one queue for each target and priority pair. The block keeps each queue's base, length, enable, write slot and generation bit in a context table. It drives a single memory write request, and once that write has been acknowledged it sends a one-cycle notify strobe toward the presenter.

The consumer software polls each queue without a shared read pointer. Bit 31 of every record is a generation bit that changes value each time the queue wraps, so a record whose generation matches the pass the reader expects is a new one. Software fills the context table through a write-only configuration port. Notifications that are addressed to a queue which is not set up are discarded and counted.

Top module: `evq_writer`

## Requirements
- R1: After reset, ev_ready is 1, mem_req and ntf_valid are 0, err_count is 0, and every queue is disabled.
- R2: A posted record is mem_wdata = {generation, ev_data[30:0]}. It is written at mem_addr = (base with bits 1:0 cleared) + 4 × slot.
- R3: The queue number is {ev_target, ev_prio}, with the target in the upper bits. Each queue keeps its own slot and generation, and posts to one queue leave the others unchanged.
- R4: A queue's slot increases by one for each completed write. After slot len−1 it returns to 0.
- R5: Configuring a queue sets its generation bit to 1. The bit inverts each time the slot returns to 0.
- R6: A notification for a queue whose enable is 0, or whose length is 0, is accepted and then discarded. It causes no memory write and no notify, and it raises err_count by one. err_count saturates at its maximum.
- R7: ntf_valid is high for exactly one cycle, in the cycle after the cycle where mem_req and mem_ack were both high. It carries the target and priority of that record.
- R8: Only one notification is in flight at a time. ev_ready stays low while mem_req is high, and mem_addr and mem_wdata stay stable until mem_ack.
- R9: A configuration write sets the queue's slot to 0 and its generation to 1. If it lands in the same cycle as a completed write to that queue, the configuration takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Notification offered |
| ev_ready | output | 1 | Block can accept a notification |
| ev_data | input | 31 | Event data word |
| ev_target | input | TGT_W | Target number |
| ev_prio | input | PRIO_W | Priority |
| mem_req | output | 1 | Memory write request |
| mem_ack | input | 1 | Memory write accepted |
| mem_addr | output | ADDR_W | Byte address of the record |
| mem_wdata | output | 32 | Record: generation bit and event data |
| ntf_valid | output | 1 | Notify strobe to presenter |
| ntf_target | output | TGT_W | Target of the posted record |
| ntf_prio | output | PRIO_W | Priority of the posted record |
| cfg_we | input | 1 | Configuration write |
| cfg_qid | input | TGT_W+PRIO_W | Queue being configured |
| cfg_base | input | ADDR_W | Queue base byte address |
| cfg_len | input | IDX_W+1 | Queue length in records |
| cfg_en | input | 1 | Queue enable |
| err_count | output | ERR_W | Discarded-notification count |

## Verification
A slot update from a completed write and a configuration write can hit the same queue in the same cycle. The bench holds back mem_ack on a pending write. It then releases the acknowledge in the same cycle that it reconfigures that queue with a new base. The outcome is judged on the next post to the queue: it must land in slot 0 of the new base with generation 1, while the held write itself still goes out to its old address.

// File: rtl/evq_pkg.sv
package evq_pkg;

  localparam int EVQ_DATA_W  = 31;
  localparam int EVQ_ENTRY_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WRITE  = 2'd1,
    ST_NOTIFY = 2'd2
  } evq_state_e;

  // Record layout: generation in the top bit, event data below.
  function automatic logic [EVQ_ENTRY_W-1:0] pack_entry(
      input logic gen, input logic [EVQ_DATA_W-1:0] data);
    return {gen, data};
  endfunction

endpackage

// File: rtl/evq_ctx_table.sv
module evq_ctx_table #(
  parameter int NQ_W   = 6,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [NQ_W-1:0]   cfg_qid,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W:0]    cfg_len,
  input  logic              cfg_en,
  input  logic [NQ_W-1:0]   lk_qid,
  output logic              lk_ok,
  output logic [ADDR_W-1:0] lk_addr,
  output logic              lk_gen,
  input  logic              adv_en,
  input  logic [NQ_W-1:0]   adv_qid
);

  localparam int NQ = 1 << NQ_W;

  function automatic logic at_end(input logic [IDX_W-1:0] idx, input logic [IDX_W:0] len);
    logic [IDX_W:0] nxt;
    nxt = {1'b0, idx} + 1'b1;
    return nxt == len;
  endfunction

  function automatic logic [IDX_W-1:0] step_slot(input logic [IDX_W-1:0] idx,
                                                 input logic [IDX_W:0] len);
    return at_end(idx, len) ? '0 : idx + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
    return (base & ~ADDR_W'(3)) + (ADDR_W'(idx) << 2);
  endfunction

  logic [NQ-1:0][ADDR_W-1:0] base_v;
  logic [NQ-1:0][IDX_W:0]    len_v;
  logic [NQ-1:0][IDX_W-1:0]  slot_v;
  logic [NQ-1:0]             live_v;
  logic [NQ-1:0]             gen_v;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [ADDR_W-1:0] base_r;
    logic [IDX_W:0]    len_r;
    logic [IDX_W-1:0]  slot_r;
    logic              live_r;
    logic              gen_r;
    logic              hit_cfg;
    logic              hit_adv;

    assign hit_cfg = cfg_we && (cfg_qid == NQ_W'(q));
    assign hit_adv = adv_en && (adv_qid == NQ_W'(q));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_r <= '0;
        len_r  <= '0;
        slot_r <= '0;
        live_r <= 1'b0;
        gen_r  <= 1'b1;
      end else if (hit_cfg) begin
        base_r <= cfg_base;
        len_r  <= cfg_len;
        live_r <= cfg_en;
        slot_r <= '0;
        gen_r  <= 1'b1;
      end else if (hit_adv) begin
        slot_r <= step_slot(slot_r, len_r);
        if (at_end(slot_r, len_r)) gen_r <= ~gen_r;
      end
    end

    assign base_v[q] = base_r;
    assign len_v[q]  = len_r;
    assign slot_v[q] = slot_r;
    assign live_v[q] = live_r;
    assign gen_v[q]  = gen_r;
  end

  assign lk_ok   = live_v[lk_qid] && (len_v[lk_qid] != '0);
  assign lk_addr = slot_addr(base_v[lk_qid], slot_v[lk_qid]);
  assign lk_gen  = gen_v[lk_qid];

endmodule

// File: rtl/evq_post_ctl.sv
module evq_post_ctl #(
  parameter int TGT_W  = 3,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 32,
  localparam int NQ_W  = TGT_W + PRIO_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ev_valid,
  output logic                         ev_ready,
  input  logic [evq_pkg::EVQ_DATA_W-1:0] ev_data,
  input  logic [TGT_W-1:0]             ev_target,
  input  logic [PRIO_W-1:0]            ev_prio,
  output logic [NQ_W-1:0]              lk_qid,
  input  logic                         lk_ok,
  input  logic [ADDR_W-1:0]            lk_addr,
  input  logic                         lk_gen,
  output logic                         mem_req,
  input  logic                         mem_ack,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [evq_pkg::EVQ_ENTRY_W-1:0] mem_wdata,
  output logic                         ntf_valid,
  output logic [TGT_W-1:0]             ntf_target,
  output logic [PRIO_W-1:0]            ntf_prio,
  output logic                         adv_en,
  output logic [NQ_W-1:0]              adv_qid,
  output logic                         drop_evt
);

  import evq_pkg::*;

  evq_state_e                 state_q;
  logic [NQ_W-1:0]            qid_q;
  logic [ADDR_W-1:0]          addr_q;
  logic [EVQ_ENTRY_W-1:0]     wdata_q;
  logic                       accept;

  assign ev_ready = (state_q == ST_IDLE);
  assign lk_qid   = {ev_target, ev_prio};
  assign accept   = ev_ready && ev_valid;
  assign drop_evt = accept && !lk_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      qid_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept && lk_ok) begin
          state_q <= ST_WRITE;
          qid_q   <= lk_qid;
          addr_q  <= lk_addr;
          wdata_q <= pack_entry(lk_gen, ev_data);
        end
        ST_WRITE:  if (mem_ack) state_q <= ST_NOTIFY;
        ST_NOTIFY: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req    = (state_q == ST_WRITE);
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;
  assign adv_en     = mem_req && mem_ack;
  assign adv_qid    = qid_q;
  assign ntf_valid  = (state_q == ST_NOTIFY);
  assign ntf_target = qid_q[NQ_W-1:PRIO_W];
  assign ntf_prio   = qid_q[PRIO_W-1:0];

endmodule

// File: rtl/evq_err_cnt.sv
module evq_err_cnt #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [ERR_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (bump && !(&count)) count <= count + 1'b1;
  end

endmodule

// File: rtl/evq_writer.sv
module evq_writer #(
  parameter int TGT_W  = 3,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int ERR_W  = 8,
  localparam int NQ_W  = TGT_W + PRIO_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_valid,
  output logic                ev_ready,
  input  logic [30:0]         ev_data,
  input  logic [TGT_W-1:0]    ev_target,
  input  logic [PRIO_W-1:0]   ev_prio,
  output logic                mem_req,
  input  logic                mem_ack,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [31:0]         mem_wdata,
  output logic                ntf_valid,
  output logic [TGT_W-1:0]    ntf_target,
  output logic [PRIO_W-1:0]   ntf_prio,
  input  logic                cfg_we,
  input  logic [NQ_W-1:0]     cfg_qid,
  input  logic [ADDR_W-1:0]   cfg_base,
  input  logic [IDX_W:0]      cfg_len,
  input  logic                cfg_en,
  output logic [ERR_W-1:0]    err_count
);

  logic [NQ_W-1:0]   lk_qid;
  logic              lk_ok;
  logic [ADDR_W-1:0] lk_addr;
  logic              lk_gen;
  logic              commit_evt;
  logic [NQ_W-1:0]   adv_qid;
  logic              drop_evt;

  evq_ctx_table #(.NQ_W(NQ_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctx (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_qid(cfg_qid), .cfg_base(cfg_base),
    .cfg_len(cfg_len), .cfg_en(cfg_en),
    .lk_qid(lk_qid), .lk_ok(lk_ok), .lk_addr(lk_addr), .lk_gen(lk_gen),
    .adv_en(commit_evt), .adv_qid(adv_qid)
  );

  evq_post_ctl #(.TGT_W(TGT_W), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_data(ev_data),
    .ev_target(ev_target), .ev_prio(ev_prio),
    .lk_qid(lk_qid), .lk_ok(lk_ok), .lk_addr(lk_addr), .lk_gen(lk_gen),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ntf_valid(ntf_valid), .ntf_target(ntf_target), .ntf_prio(ntf_prio),
    .adv_en(commit_evt), .adv_qid(adv_qid), .drop_evt(drop_evt)
  );

  evq_err_cnt #(.ERR_W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .bump(drop_evt), .count(err_count)
  );

endmodule

// File: rtl/evq_writer_chk.sv
module evq_writer_chk #(
  parameter int ADDR_W = 32,
  parameter int ERR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_ready,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              ntf_valid,
  input logic [ERR_W-1:0]  err_count,
  input logic              drop_evt,
  input logic              commit_evt
);

  assert_hold_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !ev_ready);

  assert_ntf_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> ntf_valid);

  assert_ntf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> $past(commit_evt));

  assert_ntf_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |=> !ntf_valid);

  assert_drop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !mem_req && !ntf_valid);

  assert_err_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count != $past(err_count)) |-> (err_count == $past(err_count) + 1'b1));

  assert_err_bump_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (err_count == $past(err_count) + 1'b1) || (&err_count));

endmodule

bind evq_writer evq_writer_chk #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_ready(ev_ready), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .ntf_valid(ntf_valid), .err_count(err_count),
  .drop_evt(drop_evt), .commit_evt(commit_evt)
);

// File: tb/evq_writer_test.sv
`timescale 1ns/1ps
module evq_writer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [30:0] ev_data = '0;
  logic [2:0]  ev_target = '0;
  logic [2:0]  ev_prio = '0;
  logic        mem_req;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        ntf_valid;
  logic [2:0]  ntf_target;
  logic [2:0]  ntf_prio;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_qid = '0;
  logic [31:0] cfg_base = '0;
  logic [8:0]  cfg_len = '0;
  logic        cfg_en = 1'b0;
  logic [7:0]  err_count;

  always #2.5 clk = ~clk;

  evq_writer uut (.*);

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_base [64];
  int          m_len  [64];
  bit          m_en   [64];
  int          m_slot [64];
  bit          m_gen  [64];
  int          exp_err = 0;

  logic [31:0] q_addr [$];
  logic [31:0] q_data [$];
  int          q_ntf  [$];
  string       addr_tag = "R2";

  bit hold_ack = 1'b0;
  bit force_ack = 1'b0;
  bit ack_ph = 1'b0;
  bit prev_ack = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic configure(input int q, input logic [31:0] base, input int len, input bit en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_qid = 6'(q); cfg_base = base; cfg_len = 9'(len); cfg_en = en;
    @(negedge clk);
    cfg_we = 1'b0;
    m_base[q] = base; m_len[q] = len; m_en[q] = en; m_slot[q] = 0; m_gen[q] = 1'b1;
  endtask

  task automatic post(input int t, input int p, input logic [30:0] d);
    int q = t * 8 + p;
    bit ok = m_en[q] && (m_len[q] != 0);
    if (ok) begin
      q_addr.push_back((m_base[q] & ~32'h3) + 32'(m_slot[q] * 4));
      q_data.push_back({m_gen[q], d});
      q_ntf.push_back(q);
      m_slot[q]++;
      if (m_slot[q] == m_len[q]) begin
        m_slot[q] = 0;
        m_gen[q] = ~m_gen[q];
      end
    end else begin
      exp_err = (exp_err == 255) ? 255 : exp_err + 1;
    end
    @(negedge clk);
    ev_valid = 1'b1; ev_target = 3'(t); ev_prio = 3'(p); ev_data = d;
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
    if (!ok) begin
      chk(err_count == 8'(exp_err), "R6", "err_count", err_count, exp_err);
      chk(!mem_req, "R6", "mem_req after drop", mem_req, 0);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ev_ready && q_addr.size() == 0 && q_ntf.size() == 0 && !ntf_valid) break;
    end
    chk(q_addr.size() == 0, "R7", "writes outstanding", q_addr.size(), 0);
    chk(q_ntf.size() == 0, "R7", "notifies outstanding", q_ntf.size(), 0);
  endtask

  // Memory responder and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (hold_ack) mem_ack = mem_req && force_ack;
        else          mem_ack = mem_req && ack_ph;
        ack_ph = ~ack_ph;
        if (mem_req) chk(!ev_ready, "R8", "ev_ready while busy", ev_ready, 0);
        if (mem_req && mem_ack) begin
          if (q_addr.size() == 0) begin
            chk(1'b0, "R6", "unexpected write", mem_addr, 0);
          end else begin
            logic [31:0] ea;
            logic [31:0] ed;
            ea = q_addr.pop_front();
            ed = q_data.pop_front();
            chk(mem_addr == ea, addr_tag, "mem_addr", mem_addr, ea);
            chk(mem_wdata[30:0] == ed[30:0], "R2", "record data", mem_wdata[30:0], ed[30:0]);
            chk(mem_wdata[31] == ed[31], "R5", "generation", mem_wdata[31], ed[31]);
          end
        end
        if (ntf_valid) begin
          chk(prev_ack, "R7", "notify without prior ack", 0, 1);
          if (q_ntf.size() == 0) begin
            chk(1'b0, "R7", "unexpected notify", {ntf_target, ntf_prio}, 0);
          end else begin
            int en;
            en = q_ntf.pop_front();
            chk({ntf_target, ntf_prio} == 6'(en), "R3", "notify target/prio",
                {ntf_target, ntf_prio}, en);
          end
        end else if (prev_ack) begin
          chk(1'b0, "R7", "notify missing after ack", 0, 1);
        end
        prev_ack = mem_req && mem_ack;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  localparam int QA = 1 * 8 + 2;
  localparam int QB = 5 * 8 + 0;
  localparam int QC = 4 * 8 + 4;

  initial begin
    for (int i = 0; i < 64; i++) begin
      m_base[i] = '0; m_len[i] = 0; m_en[i] = 1'b0; m_slot[i] = 0; m_gen[i] = 1'b1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk(ev_ready == 1'b1, "R1", "ev_ready", ev_ready, 1);
    chk(mem_req == 1'b0, "R1", "mem_req", mem_req, 0);
    chk(ntf_valid == 1'b0, "R1", "ntf_valid", ntf_valid, 0);
    chk(err_count == 8'd0, "R1", "err_count", err_count, 0);

    // R1 / R6: unconfigured queue is disabled after reset
    post(6, 1, 31'h11);

    configure(QA, 32'h0000_1003, 3, 1'b1);   // low bits ignored (R2)
    configure(QB, 32'h0000_2000, 4, 1'b1);
    configure(QC, 32'h0000_3000, 1, 1'b1);
    configure(2 * 8 + 7, 32'h0000_4000, 4, 1'b0);
    configure(3 * 8 + 3, 32'h0000_5000, 0, 1'b1);

    // R2, R4, R5: two wraps on a three-slot queue
    addr_tag = "R4";
    for (int i = 0; i < 7; i++) post(1, 2, 31'h100 + 31'(i));
    drain();

    // R3: interleaved queues keep separate slots
    addr_tag = "R3";
    for (int i = 0; i < 6; i++) begin
      post(5, 0, 31'h7FFF_0000 + 31'(i));
      post(1, 2, 31'h2A0 + 31'(i));
    end
    drain();

    // R5: one-slot queue flips generation on every record
    addr_tag = "R5";
    for (int i = 0; i < 4; i++) post(4, 4, 31'h5555_5555 ^ 31'(i));
    drain();

    // R6: disabled and zero-length queues
    post(2, 7, 31'h1);
    post(3, 3, 31'h2);
    drain();

    // R9: plain reconfiguration resets slot and generation
    addr_tag = "R9";
    post(5, 0, 31'h33);
    drain();
    configure(QB, 32'h0000_6000, 4, 1'b1);
    post(5, 0, 31'h34);
    drain();

    // R9: configuration and write completion in the same cycle
    hold_ack = 1'b1; force_ack = 1'b0;
    post(1, 2, 31'h0ABC);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_qid = 6'(QA); cfg_base = 32'h0000_7000; cfg_len = 9'd3; cfg_en = 1'b1;
    force_ack = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0; force_ack = 1'b0; hold_ack = 1'b0;
    m_base[QA] = 32'h0000_7000; m_len[QA] = 3; m_en[QA] = 1'b1; m_slot[QA] = 0; m_gen[QA] = 1'b1;
    drain();
    post(1, 2, 31'h0ABD);
    post(1, 2, 31'h0ABE);
    drain();

    // R6: counter saturates
    for (int i = 0; i < 256; i++) post(6, 1, 31'(i));
    chk(err_count == 8'hFF, "R6", "saturated err_count", err_count, 8'hFF);
    drain();

    finish_run();
  end

endmodule